// File: doc/BRIEF.md
# GPIO Bank Port Registers with Masked Writes

This block holds the pin-level control state for one bank of general-purpose pins, organised as four ports of eight pins each. For every port there are three writable bytes: a function select (pin used as GPIO or left to its alternate function), an output enable and an output value. A fourth, read-only location per port returns the pad levels after a two-flop synchronizer. The state drives the pad-facing output-enable, output-value and function-select vectors directly.

Each writable register answers at two addresses. A plain write replaces the whole byte. The masked alias, at the plain address plus 0x800, carries an update mask in the second byte of the write data next to the new pin values in the first byte, so one bus write can set or clear chosen pins without a read-modify-write sequence and without racing another agent that owns other pins of the same port.

The bus is a simple single-cycle select/write strobe with a registered read return one cycle later.

Top module: `gpio_bank_regs`

## Requirements
- R1: After synchronous reset every function-select, output-enable and output-value bit is 0 and the read-data output is 0.
- R2: A write with the select and write strobes high at a plain address (function select 0x00+4p, output enable 0x10+4p, output value 0x20+4p, port p in 0..3) loads write-data bits 7:0 into that register; write-data bits 31:8 are ignored.
- R3: A write at a plain address plus 0x800 updates pin n of the addressed register to write-data bit n only when write-data bit 8+n is 1; pins whose bit 8+n is 0 keep their value.
- R4: A read (select high, write low) returns on the read-data output, one cycle later, the addressed register in bits 7:0 and zeros in bits 31:8, at both the plain and the masked address.
- R5: The input location 0x30+4p returns the pad levels of port p through two synchronizing flops; a pad change is visible to a read sampled at the third rising edge after the change, and writes to this location at either address change nothing.
- R6: Bit n of port p maps to pin index 8p+n on every pad-facing vector.
- R7: The pad output-enable, output-value and function-select vectors follow the registers in the cycle after the write.
- R8: An access whose address has any of bits 10:7 or bits 1:0 set, or bit 6 set, writes nothing and reads back 0.
- R9: A write to one register of one port leaves every other register of every port unchanged.
- R10: Writing the output value while the output enable is 0 and raising the output enable afterwards leaves the output value stable across the enable write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address within the bank window |
| bus_wdata | input | 32 | Write data; bits 15:8 are the mask in a masked write |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_oe | output | 32 | Per-pin output enable |
| pad_do | output | 32 | Per-pin output value |
| pin_gpio | output | 32 | Per-pin GPIO function select |

## Verification
The masked path is driven with a partial mask that both sets and clears bits, a full mask of clears, and an empty mask carrying all-ones data; together these separate a correct merge from a plain overwrite, an inverted mask and a mask that is ignored. Plain writes with garbage in the upper data bits show the upper bits are dropped, and reads of untouched registers after writes elsewhere expose crosstalk between ports or register kinds. Out-of-window, misaligned and input-location writes tell a decoder that matches too loosely from a correct one, and a pad change read back at each of three successive edges pins the synchronizer depth exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PORT_PINS  = 8;
    localparam int N_PORTS    = 4;
    localparam int PORT_IDX_W = $clog2(N_PORTS);
    localparam int BUS_ADDR_W = 12;
    localparam int BUS_DATA_W = 32;
    localparam int ALIAS_BIT  = 11;

    typedef logic [PORT_PINS-1:0] pin_byte_t;

    typedef enum logic [1:0] {
        RK_FUNC = 2'd0,
        RK_OEN  = 2'd1,
        RK_DOUT = 2'd2,
        RK_PIN  = 2'd3
    } reg_kind_e;

    localparam int N_WREGS = 3;

    typedef struct packed {
        logic                  hit;
        logic                  masked;
        reg_kind_e             kind;
        logic [PORT_IDX_W-1:0] port;
    } dec_t;

    function automatic pin_byte_t merge_pins(
        input pin_byte_t cur,
        input pin_byte_t val,
        input pin_byte_t sel,
        input logic      masked
    );
        if (masked) return (cur & ~sel) | (val & sel);
        return val;
    endfunction

endpackage

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int KIND_LSB = PORT_IDX_W + 2;

    logic in_window;

    always_comb begin
        in_window = (addr[ALIAS_BIT-1:KIND_LSB+2] == '0) && (addr[1:0] == 2'b00);
        dec.hit    = in_window;
        dec.masked = addr[ALIAS_BIT];
        dec.kind   = reg_kind_e'(addr[KIND_LSB+1:KIND_LSB]);
        dec.port   = addr[KIND_LSB-1:2];
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (q == $past(d, 2))); // R5

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_WREGS-1:0] wr_en,
    input  logic               masked,
    input  pin_byte_t          wr_val,
    input  pin_byte_t          wr_sel,
    output pin_byte_t          func_q,
    output pin_byte_t          oen_q,
    output pin_byte_t          dout_q
);
    pin_byte_t regs_q [N_WREGS];

    for (genvar k = 0; k < N_WREGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)           regs_q[k] <= '0;
            else if (wr_en[k]) regs_q[k] <= merge_pins(regs_q[k], wr_val, wr_sel, masked);
        end

        AST_MASK_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
            (wr_en[k] && masked) |=>
            (((regs_q[k] ^ $past(regs_q[k])) & ~$past(wr_sel)) == '0)); // R3

        AST_MASK_SETS_BITS: assert property (@(posedge clk) disable iff (rst)
            (wr_en[k] && masked) |=>
            (((regs_q[k] ^ $past(wr_val)) & $past(wr_sel)) == '0)); // R3

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !wr_en[k] |=> $stable(regs_q[k])); // R9
    end

    assign func_q = regs_q[0];
    assign oen_q  = regs_q[1];
    assign dout_q = regs_q[2];

    AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en)); // R9

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPORT  = N_PORTS,
    parameter int NPINS  = PORT_PINS,
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPORT*NPINS-1:0] pad_in,
    output logic [NPORT*NPINS-1:0] pad_oe,
    output logic [NPORT*NPINS-1:0] pad_do,
    output logic [NPORT*NPINS-1:0] pin_gpio
);
    localparam int NPIN_ALL = NPORT * NPINS;

    dec_t dec;

    gpio_bank_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    logic [NPIN_ALL-1:0] pad_sync;

    gpio_in_sync #(.W(NPIN_ALL)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    logic wr_hit;
    logic rd_req;
    assign wr_hit = bus_sel && bus_wr && dec.hit && (dec.kind != RK_PIN);
    assign rd_req = bus_sel && !bus_wr;

    pin_byte_t wr_val;
    pin_byte_t wr_sel;
    assign wr_val = bus_wdata[NPINS-1:0];
    assign wr_sel = bus_wdata[2*NPINS-1:NPINS];

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2*NPINS];

    pin_byte_t func_b [NPORT];
    pin_byte_t oen_b  [NPORT];
    pin_byte_t dout_b [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [N_WREGS-1:0] we;
        always_comb begin
            we = '0;
            if (wr_hit && (dec.port == PORT_IDX_W'(p))) begin
                we[dec.kind] = 1'b1;
            end
        end

        gpio_port_regs u_port (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (we),
            .masked (dec.masked),
            .wr_val (wr_val),
            .wr_sel (wr_sel),
            .func_q (func_b[p]),
            .oen_q  (oen_b[p]),
            .dout_q (dout_b[p])
        );

        assign pin_gpio[p*NPINS +: NPINS] = func_b[p];
        assign pad_oe  [p*NPINS +: NPINS] = oen_b[p];
        assign pad_do  [p*NPINS +: NPINS] = dout_b[p];
    end

    pin_byte_t rd_byte;
    always_comb begin
        rd_byte = '0;
        if (dec.hit) begin
            unique case (dec.kind)
                RK_FUNC: rd_byte = func_b[dec.port];
                RK_OEN:  rd_byte = oen_b[dec.port];
                RK_DOUT: rd_byte = dout_b[dec.port];
                RK_PIN:  rd_byte = pad_sync[dec.port*NPINS +: NPINS];
                default: rd_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_req) bus_rdata <= {{(DATA_W-NPINS){1'b0}}, rd_byte};
    end

    AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NPINS] == '0); // R4

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !dec.hit) |=> (bus_rdata == '0)); // R8

    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !dec.hit) |=>
        ($stable(pad_oe) && $stable(pad_do) && $stable(pin_gpio))); // R8

    AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && dec.hit && dec.kind == RK_PIN) |=>
        ($stable(pad_oe) && $stable(pad_do) && $stable(pin_gpio))); // R5

    AST_OEN_WRITE_KEEPS_DOUT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && dec.hit && dec.kind == RK_OEN) |=> $stable(pad_do)); // R10

endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = 32'h1234_5678;
    logic [31:0] pad_oe;
    logic [31:0] pad_do;
    logic [31:0] pin_gpio;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_bank_regs u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_do    (pad_do),
        .pin_gpio  (pin_gpio)
    );

    // {write, address, data-or-expected-read}
    localparam int NV = 25;
    localparam logic [44:0] TBL [NV] = '{
        {1'b1, 12'h010, 32'hFFFF_FF5A}, // 0  R2 plain oe p0, junk above
        {1'b0, 12'h010, 32'h0000_005A}, // 1  R2
        {1'b0, 12'h810, 32'h0000_005A}, // 2  R4 alias read
        {1'b1, 12'h810, 32'h0000_0381}, // 3  R3 set bit0, clear bit1
        {1'b0, 12'h010, 32'h0000_0059}, // 4  R3
        {1'b1, 12'h02C, 32'h0000_00C3}, // 5  R2 out p3
        {1'b0, 12'h02C, 32'h0000_00C3}, // 6  R2
        {1'b1, 12'h82C, 32'h0000_FF00}, // 7  R3 clear all
        {1'b0, 12'h82C, 32'h0000_0000}, // 8  R3
        {1'b1, 12'h82C, 32'h0000_00FF}, // 9  R3 empty mask
        {1'b0, 12'h02C, 32'h0000_0000}, // 10 R3
        {1'b1, 12'h004, 32'h0000_00A5}, // 11 R2 func p1
        {1'b0, 12'h004, 32'h0000_00A5}, // 12 R2
        {1'b0, 12'h000, 32'h0000_0000}, // 13 R9
        {1'b0, 12'h010, 32'h0000_0059}, // 14 R9
        {1'b1, 12'h034, 32'h0000_00FF}, // 15 R5 write to input
        {1'b1, 12'h834, 32'h0000_FFFF}, // 16 R5 masked write to input
        {1'b0, 12'h034, 32'h0000_0056}, // 17 R5 byte 1 of pads
        {1'b1, 12'h090, 32'h0000_00FF}, // 18 R8 out of window
        {1'b0, 12'h090, 32'h0000_0000}, // 19 R8
        {1'b0, 12'h010, 32'h0000_0059}, // 20 R8
        {1'b1, 12'h040, 32'h0000_00FF}, // 21 R8 bit 6
        {1'b0, 12'h040, 32'h0000_0000}, // 22 R8
        {1'b1, 12'h012, 32'h0000_00FF}, // 23 R8 misaligned
        {1'b0, 12'h010, 32'h0000_0059}  // 24 R8
    };

    function automatic string row_tag(input int i);
        case (i)
            2:             return "R4";
            4, 8, 10:      return "R3";
            13, 14:        return "R9";
            17:            return "R5";
            19, 20, 22, 24: return "R8";
            default:       return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [11:0] a, input logic [31:0] d);
        bus_sel   = 1'b1;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe",   pad_oe,    32'h0);
        chk("R1 pad_do",   pad_do,    32'h0);
        chk("R1 pin_gpio", pin_gpio,  32'h0);
        chk("R1 rdata",    bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(TBL[i][44], TBL[i][43:32], TBL[i][31:0]);
            if (!TBL[i][44]) chk($sformatf("%s row %0d", row_tag(i), i), bus_rdata, TBL[i][31:0]);
        end

        // R10 output value first, then enable
        bus_op(1'b1, 12'h028, 32'h0000_003C);
        chk("R10 oe still low",  {24'h0, pad_oe[23:16]}, 32'h0);
        chk("R10 value ready",   {24'h0, pad_do[23:16]}, 32'h3C);
        bus_op(1'b1, 12'h018, 32'h0000_00F0);
        chk("R10 oe raised",     {24'h0, pad_oe[23:16]}, 32'hF0);
        chk("R10 value kept",    {24'h0, pad_do[23:16]}, 32'h3C);

        // R6 and R7 pin mapping on full vectors
        chk("R6 pad_oe map", pad_oe, 32'h00F0_0059);
        chk("R6 pad_do map", pad_do, 32'h003C_0000);
        bus_op(1'b1, 12'h008, 32'h0000_0081);
        chk("R7 pin_gpio", pin_gpio, 32'h0081_A500);
        bus_op(1'b1, 12'h808, 32'h0000_8000);
        chk("R3 func alias clear", pin_gpio, 32'h0001_A500);

        // R5 synchronizer depth: change pads and read on three successive edges
        pad_in = 32'hAB34_5678;
        bus_op(1'b0, 12'h03C, 32'h0);
        chk("R5 edge1 old", bus_rdata, 32'h12);
        bus_op(1'b0, 12'h03C, 32'h0);
        chk("R5 edge2 old", bus_rdata, 32'h12);
        bus_op(1'b0, 12'h03C, 32'h0);
        chk("R5 edge3 new", bus_rdata, 32'hAB);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 re-reset pad_oe",   pad_oe,    32'h0);
        chk("R1 re-reset pad_do",   pad_do,    32'h0);
        chk("R1 re-reset pin_gpio", pin_gpio,  32'h0);
        chk("R1 re-reset rdata",    bus_rdata, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule